// File: doc/BRIEF.md
# Flash Block Erase-and-Verify Sequencer

This block runs the full erase procedure for a bank of equally sized flash blocks without processor help. A start strobe hands it a mask of the blocks to clear. It takes the selected blocks one at a time, lowest index first. For each block it raises the array strobes in a fixed order: write enable, erase setup, erase pulse, then erase-verify mode. Between each pair of switches it waits a programmable number of cycles. It then sweeps the block word by word. Each word gets a dummy write of all ones, a settling wait and a word read, and the read value must be all ones.

A word that reads back wrong ends the sweep. The sequencer leaves verify mode and gives the same block another erase pulse. After a set number of pulses that all fail, it reports the failing block and stops. There is no pre-programming pass to all zeros; each block starts straight with the erase steps. Block base addresses come from the block index times a fixed block size. All waits and the pulse limit are input values counted in clock cycles. They must be held steady while the sequencer is busy.

States and transitions: `ST_IDLE` goes to `ST_WEN` on a start with a non-empty mask, or to `ST_END` on a start with an empty mask. `ST_WEN` (write enable on) goes to `ST_SETUP` (setup on, block picked). From there it goes to `ST_PULSE` (erase pulse), then `ST_HOLD` (pulse off, setup on), then `ST_UNSET` (setup off), then `ST_VENTER` (verify on). The word loop runs `ST_VWR` (dummy write), `ST_VWAIT`, `ST_VRD` (read) and `ST_VCHK` (compare). `ST_VCHK` returns to `ST_VWR` for the next word, or moves to `ST_VEXIT` on a mismatch or after the last word. `ST_VEXIT` (verify off) goes back to `ST_SETUP` for a retry or for the next block, or to `ST_END`. `ST_END` drops write enable, pulses done and returns to `ST_IDLE`. Each wait state ends through its timer.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, busy, done, fail, all four array strobes, the block select and both access strobes are low.
- R2: A start with an all-zero mask raises done, with fail low, in the cycle after the start strobe, and no array strobe or access toggles.
- R3: Selected blocks are handled one at a time in ascending index order. During setup, pulse and verify, the block select carries exactly one set bit, equal to the current block.
- R4: Write enable is high before erase setup rises. The erase pulse is only high while setup and write enable are high. Verify mode is never high together with setup or pulse.
- R5: Every erase pulse stays high for exactly t_pulse+1 cycles. The write-enable-only interval before the first setup lasts t_step+1 cycles.
- R6: For each verify word, the sequencer writes 0xFFFF to that word's address, which lies inside the current block. The read of the same word follows t_rd+2 cycles after the write.
- R7: A block passes when every word of it, up to and including the last, reads 0xFFFF. The next selected block then starts. After the last selected block, done rises with fail low.
- R8: A word read other than 0xFFFF ends the sweep and triggers another erase pulse on the same block. A block receives at most max(max_tries,1) pulses, and exactly as many as it needs when that fits.
- R9: When a block still fails after max(max_tries,1) pulses, done rises with fail high and fail_blk set to that block's index. Later selected blocks receive no pulse.
- R10: busy is high from the cycle after an accepted start until the cycle after done. Start strobes while busy have no effect on the operation.
- R11: done is high for one cycle and fail is only high with done. fail_blk keeps its value until the next accepted start, which clears fail state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, sampled in idle |
| blk_mask | input | NUM_BLK | Blocks to erase, bit i = block i |
| t_step | input | WAIT_W | Wait between strobe switches, cycles minus one |
| t_pulse | input | WAIT_W | Erase pulse length, cycles minus one |
| t_rd | input | WAIT_W | Wait between dummy write and read, cycles minus one |
| max_tries | input | TRY_W | Pulse limit per block (0 treated as 1) |
| fl_wen | output | 1 | Array write enable |
| fl_esetup | output | 1 | Array erase setup |
| fl_epulse | output | 1 | Array erase pulse |
| fl_verify | output | 1 | Array erase-verify mode |
| fl_blk_sel | output | NUM_BLK | One-hot block select to the array |
| mem_addr | output | ADDR_W | Word address of verify access |
| mem_we | output | 1 | Dummy write strobe |
| mem_wdata | output | DATA_W | Dummy write data |
| mem_re | output | 1 | Read strobe, data returned the following cycle |
| mem_rdata | input | DATA_W | Read data from the array |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Failure flag, valid with done |
| fail_blk | output | BI_W | Index of the block that failed |

## Verification
The hardest condition to reach is a block that passes only on its final permitted pulse. Next to it is a block that fails one pulse short, with blocks after it left untouched. The bench's array model holds a per-word count of pulses that word needs before it reads back all ones. Directed cases place a slow word at the last address of an inner block and set the pulse limit just above, at and below that count. Random runs draw masks, wait values, pulse limits and per-word needs from a seeded generator. A start strobe issued in the middle of a run with a different mask checks that the ignored request leaves the pulse counts unchanged.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WEN,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_UNSET,
        ST_VENTER,
        ST_VWR,
        ST_VWAIT,
        ST_VRD,
        ST_VCHK,
        ST_VEXIT,
        ST_END
    } fes_state_t;

endpackage

// File: rtl/fes_wait_timer.sv
module fes_wait_timer #(
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [WAIT_W-1:0] limit,
    output logic              hit
);
    logic [WAIT_W-1:0] cnt_q;

    // Counts cycles spent in the current state; cleared on each state change.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hit = (cnt_q == limit);
endmodule

// File: rtl/fes_blk_pick.sv
module fes_blk_pick #(
    parameter int NUM_BLK = 4,
    parameter int BI_W    = 2
) (
    input  logic [NUM_BLK-1:0] pend,
    output logic [BI_W-1:0]    idx,
    output logic [NUM_BLK-1:0] onehot,
    output logic               any
);
    // Lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = NUM_BLK - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx = BI_W'(i);
            end
        end
    end

    assign onehot = pend & (~pend + 1'b1);
    assign any    = |pend;
endmodule

// File: rtl/fes_word_addr.sv
module fes_word_addr #(
    parameter int NUM_BLK   = 4,
    parameter int BLK_WORDS = 8,
    parameter int BI_W      = 2,
    parameter int ADDR_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    input  logic [BI_W-1:0]   blk_idx,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam int OFF_W = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1;
    localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(BLK_WORDS - 1);

    logic [OFF_W-1:0] off_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q <= '0;
        end else if (clr) begin
            off_q <= '0;
        end else if (inc) begin
            off_q <= off_q + 1'b1;
        end
    end

    // Block base is index times block size; word offset added on top.
    assign addr = ADDR_W'(blk_idx) * ADDR_W'(BLK_WORDS) + ADDR_W'(off_q);
    assign last = (off_q == OFF_LAST);
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import flash_erase_pkg::*;
#(
    parameter int NUM_BLK   = 4,
    parameter int BLK_WORDS = 8,
    parameter int DATA_W    = 16,
    parameter int WAIT_W    = 8,
    parameter int TRY_W     = 4,
    localparam int BI_W     = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1,
    localparam int ADDR_W   = $clog2(NUM_BLK * BLK_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [NUM_BLK-1:0] blk_mask,
    input  logic [WAIT_W-1:0]  t_step,
    input  logic [WAIT_W-1:0]  t_pulse,
    input  logic [WAIT_W-1:0]  t_rd,
    input  logic [TRY_W-1:0]   max_tries,
    output logic               fl_wen,
    output logic               fl_esetup,
    output logic               fl_epulse,
    output logic               fl_verify,
    output logic [NUM_BLK-1:0] fl_blk_sel,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_we,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic               mem_re,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               busy,
    output logic               done,
    output logic               fail,
    output logic [BI_W-1:0]    fail_blk
);
    localparam logic [DATA_W-1:0] ERASED = '1;

    fes_state_t state_q, state_d;

    logic [NUM_BLK-1:0] pend_q;
    logic [NUM_BLK-1:0] cur_oh_q;
    logic [BI_W-1:0]    cur_idx_q;
    logic [TRY_W-1:0]   tries_q;
    logic               bad_q;
    logic               fail_q;
    logic [BI_W-1:0]    fail_blk_q;

    logic               tmr_hit, tmr_clr;
    logic [WAIT_W-1:0]  tmr_limit;
    logic [BI_W-1:0]    pick_idx;
    logic [NUM_BLK-1:0] pick_oh;
    logic               pick_any;
    logic               word_last;
    logic               addr_clr, addr_inc;
    logic               word_bad;
    logic               out_of_tries;
    logic               sel_en;

    assign word_bad     = (mem_rdata != ERASED);
    assign out_of_tries = (tries_q >= max_tries);

    // ---------------- submodules ----------------
    fes_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .limit (tmr_limit),
        .hit   (tmr_hit)
    );

    fes_blk_pick #(.NUM_BLK(NUM_BLK), .BI_W(BI_W)) u_pick (
        .pend   (pend_q),
        .idx    (pick_idx),
        .onehot (pick_oh),
        .any    (pick_any)
    );

    fes_word_addr #(
        .NUM_BLK   (NUM_BLK),
        .BLK_WORDS (BLK_WORDS),
        .BI_W      (BI_W),
        .ADDR_W    (ADDR_W)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (addr_clr),
        .inc     (addr_inc),
        .blk_idx (cur_idx_q),
        .addr    (mem_addr),
        .last    (word_last)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = (|blk_mask) ? ST_WEN : ST_END;
                end
            end
            ST_WEN:    if (tmr_hit) state_d = ST_SETUP;
            ST_SETUP:  if (tmr_hit) state_d = ST_PULSE;
            ST_PULSE:  if (tmr_hit) state_d = ST_HOLD;
            ST_HOLD:   if (tmr_hit) state_d = ST_UNSET;
            ST_UNSET:  if (tmr_hit) state_d = ST_VENTER;
            ST_VENTER: if (tmr_hit) state_d = ST_VWR;
            ST_VWR:    state_d = ST_VWAIT;
            ST_VWAIT:  if (tmr_hit) state_d = ST_VRD;
            ST_VRD:    state_d = ST_VCHK;
            ST_VCHK: begin
                if (word_bad || word_last) begin
                    state_d = ST_VEXIT;
                end else begin
                    state_d = ST_VWR;
                end
            end
            ST_VEXIT: begin
                if (tmr_hit) begin
                    if (bad_q) begin
                        state_d = out_of_tries ? ST_END : ST_SETUP;
                    end else begin
                        state_d = pick_any ? ST_SETUP : ST_END;
                    end
                end
            end
            ST_END:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- timer control ----------------
    assign tmr_clr = (state_d != state_q);

    always_comb begin
        unique case (state_q)
            ST_PULSE: tmr_limit = t_pulse;
            ST_VWAIT: tmr_limit = t_rd;
            default:  tmr_limit = t_step;
        endcase
    end

    assign addr_clr = (state_q == ST_VENTER);
    assign addr_inc = (state_q == ST_VCHK) && (state_d == ST_VWR);

    // ---------------- sequence data ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q     <= '0;
            cur_oh_q   <= '0;
            cur_idx_q  <= '0;
            tries_q    <= '0;
            bad_q      <= 1'b0;
            fail_q     <= 1'b0;
            fail_blk_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        pend_q     <= blk_mask;
                        fail_q     <= 1'b0;
                        fail_blk_q <= '0;
                    end
                end
                ST_WEN: begin
                    if (tmr_hit) begin
                        cur_idx_q <= pick_idx;
                        cur_oh_q  <= pick_oh;
                        pend_q    <= pend_q & ~pick_oh;
                        tries_q   <= '0;
                    end
                end
                ST_PULSE: begin
                    if (tmr_hit) begin
                        tries_q <= tries_q + 1'b1;
                    end
                end
                ST_VENTER: bad_q <= 1'b0;
                ST_VCHK: begin
                    if (word_bad) begin
                        bad_q <= 1'b1;
                    end
                end
                ST_VEXIT: begin
                    if (tmr_hit) begin
                        if (bad_q) begin
                            if (out_of_tries) begin
                                fail_q     <= 1'b1;
                                fail_blk_q <= cur_idx_q;
                            end
                        end else if (pick_any) begin
                            cur_idx_q <= pick_idx;
                            cur_oh_q  <= pick_oh;
                            pend_q    <= pend_q & ~pick_oh;
                            tries_q   <= '0;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        fl_wen    = 1'b0;
        fl_esetup = 1'b0;
        fl_epulse = 1'b0;
        fl_verify = 1'b0;
        sel_en    = 1'b0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        fail      = 1'b0;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_WEN:  fl_wen = 1'b1;
            ST_SETUP, ST_HOLD: begin
                fl_wen    = 1'b1;
                fl_esetup = 1'b1;
                sel_en    = 1'b1;
            end
            ST_PULSE: begin
                fl_wen    = 1'b1;
                fl_esetup = 1'b1;
                fl_epulse = 1'b1;
                sel_en    = 1'b1;
            end
            ST_UNSET, ST_VEXIT: begin
                fl_wen = 1'b1;
                sel_en = 1'b1;
            end
            ST_VENTER, ST_VWAIT, ST_VCHK: begin
                fl_wen    = 1'b1;
                fl_verify = 1'b1;
                sel_en    = 1'b1;
            end
            ST_VWR: begin
                fl_wen    = 1'b1;
                fl_verify = 1'b1;
                sel_en    = 1'b1;
                mem_we    = 1'b1;
            end
            ST_VRD: begin
                fl_wen    = 1'b1;
                fl_verify = 1'b1;
                sel_en    = 1'b1;
                mem_re    = 1'b1;
            end
            ST_END: begin
                done = 1'b1;
                fail = fail_q;
            end
            default: busy = 1'b0;
        endcase
    end

    assign fl_blk_sel = sel_en ? cur_oh_q : '0;
    assign mem_wdata  = mem_we ? ERASED : '0;
    assign fail_blk   = fail_blk_q;

endmodule

// File: rtl/fes_checker.sv
module fes_checker #(
    parameter int NUM_BLK = 4,
    parameter int DATA_W  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic               fail,
    input logic               fl_wen,
    input logic               fl_esetup,
    input logic               fl_epulse,
    input logic               fl_verify,
    input logic [NUM_BLK-1:0] fl_blk_sel,
    input logic               mem_we,
    input logic               mem_re,
    input logic [DATA_W-1:0]  mem_wdata
);
    assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_epulse || fl_verify) |-> ($countones(fl_blk_sel) == 1));

    assert_sel_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_epulse && $past(fl_epulse)) |-> $stable(fl_blk_sel));

    assert_pulse_after_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_epulse) |-> ($past(fl_esetup) && $past(fl_wen)));

    assert_setup_after_wen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_esetup) |-> $past(fl_wen));

    assert_mode_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fl_verify |-> (!fl_esetup && !fl_epulse));

    assert_dummy_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (fl_verify && (mem_wdata == '1) && !mem_re));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_fail_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done);

    assert_start_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

bind flash_erase_seq fes_checker #(
    .NUM_BLK (NUM_BLK),
    .DATA_W  (DATA_W)
) u_fes_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .fail       (fail),
    .fl_wen     (fl_wen),
    .fl_esetup  (fl_esetup),
    .fl_epulse  (fl_epulse),
    .fl_verify  (fl_verify),
    .fl_blk_sel (fl_blk_sel),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .mem_wdata  (mem_wdata)
);

// File: tb/tb_flash_erase_seq.sv
`timescale 1ns/1ps
module tb_flash_erase_seq;
    localparam int NB  = 4;
    localparam int BW  = 8;
    localparam int DW  = 16;
    localparam int WW  = 8;
    localparam int TW  = 4;
    localparam int AW  = 5;
    localparam int BIW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          start = 1'b0;
    logic [NB-1:0] blk_mask = '0;
    logic [WW-1:0] t_step = '0, t_pulse = '0, t_rd = '0;
    logic [TW-1:0] max_tries = '0;
    logic fl_wen, fl_esetup, fl_epulse, fl_verify, mem_we, mem_re;
    logic busy, done, fail;
    logic [NB-1:0]  fl_blk_sel;
    logic [AW-1:0]  mem_addr;
    logic [DW-1:0]  mem_wdata;
    logic [DW-1:0]  mem_rdata = '0;
    logic [BIW-1:0] fail_blk;

    flash_erase_seq #(.NUM_BLK(NB), .BLK_WORDS(BW), .DATA_W(DW),
                      .WAIT_W(WW), .TRY_W(TW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_mask(blk_mask),
        .t_step(t_step), .t_pulse(t_pulse), .t_rd(t_rd), .max_tries(max_tries),
        .fl_wen(fl_wen), .fl_esetup(fl_esetup), .fl_epulse(fl_epulse),
        .fl_verify(fl_verify), .fl_blk_sel(fl_blk_sel), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .fail(fail),
        .fail_blk(fail_blk));

    int n_checks = 0;
    int n_errors = 0;

    // array model state: pulses each word needs, pulses each block received
    int need [NB*BW];
    int pcnt [NB];
    int last_blk, order_err, width_err, gap_err, wr_err, step_cnt, pw, gap;
    bit gap_on, setup_seen, activity, ep_prev;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int sel_index(input logic [NB-1:0] s);
        int r = -1;
        for (int i = 0; i < NB; i++) if (s[i]) r = i;
        return r;
    endfunction

    function automatic int blk_need(input int b);
        int m = 1;
        for (int w = 0; w < BW; w++) if (need[b*BW+w] > m) m = need[b*BW+w];
        return m;
    endfunction

    // array model: read data valid the cycle after mem_re
    always @(posedge clk) begin
        if (mem_re) begin
            if (pcnt[int'(mem_addr)/BW] >= need[int'(mem_addr)])
                mem_rdata <= 16'hFFFF;
            else
                mem_rdata <= 16'hFFFF ^ (16'h1 << (int'(mem_addr) % 16));
        end
        if (fl_epulse && !ep_prev) begin
            int b;
            b = sel_index(fl_blk_sel);
            if (b >= 0) begin
                if (b < last_blk) order_err++;
                last_blk = b;
                pcnt[b]++;
            end
        end
        ep_prev <= fl_epulse;
    end

    // monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (fl_wen || fl_esetup || fl_epulse || fl_verify || mem_we || mem_re)
                activity = 1'b1;
            if (fl_epulse) pw++;
            else if (pw != 0) begin
                if (pw != int'(t_pulse) + 1) width_err++;
                pw = 0;
            end
            if (fl_esetup) setup_seen = 1'b1;
            if (fl_wen && !setup_seen) step_cnt++;
            if (gap_on) gap++;
            if (mem_we) begin
                if (mem_wdata != 16'hFFFF) wr_err++;
                if (int'(mem_addr) / BW != sel_index(fl_blk_sel)) wr_err++;
                gap_on = 1'b1;
                gap = 0;
            end
            if (mem_re) begin
                if (gap != int'(t_rd) + 2) gap_err++;
                gap_on = 1'b0;
            end
        end
    end

    task automatic run_op(input logic [NB-1:0] m, input int n, input int ts,
                          input int tp, input int tr, input int mid_at);
        int allowed, cyc, exp_p[NB], exp_fb;
        bit exp_fail;
        allowed = (n < 1) ? 1 : n;
        exp_fail = 1'b0;
        exp_fb = 0;
        for (int b = 0; b < NB; b++) begin
            exp_p[b] = 0;
            if (m[b] && !exp_fail) begin
                if (blk_need(b) <= allowed) exp_p[b] = blk_need(b);
                else begin
                    exp_p[b] = allowed;
                    exp_fail = 1'b1;
                    exp_fb = b;
                end
            end
        end
        @(negedge clk);
        for (int b = 0; b < NB; b++) pcnt[b] = 0;
        last_blk = 0; order_err = 0; width_err = 0; gap_err = 0; wr_err = 0;
        step_cnt = 0; pw = 0; gap = 0; gap_on = 0; setup_seen = 0; activity = 0;
        blk_mask = m; max_tries = TW'(n);
        t_step = WW'(ts); t_pulse = WW'(tp); t_rd = WW'(tr);
        start = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            start = 1'b0;
            blk_mask = m;
            if (cyc == 1 && m != 0) check(busy == 1'b1, "R10 busy after start", busy, 1);
            if (mid_at != 0 && cyc == mid_at) begin
                start = 1'b1;
                blk_mask = '1;
            end
        end while (!done && cyc < 20000);
        check(done == 1'b1, "R10 operation completes", done, 1);
        check(fail == exp_fail, "R7/R9 fail flag", fail, exp_fail);
        if (exp_fail) check(fail_blk == BIW'(exp_fb), "R9 fail_blk", fail_blk, exp_fb);
        for (int b = 0; b < NB; b++)
            check(pcnt[b] == exp_p[b], $sformatf("R8 pulses block %0d", b), pcnt[b], exp_p[b]);
        check(order_err == 0, "R3 ascending block order", order_err, 0);
        check(width_err == 0, "R5 pulse width", width_err, 0);
        check(gap_err == 0, "R6 write-to-read gap", gap_err, 0);
        check(wr_err == 0, "R6 dummy write data/address", wr_err, 0);
        if (m == 0) begin
            check(cyc == 1, "R2 empty mask latency", cyc, 1);
            check(activity == 1'b0, "R2 no array activity", activity, 0);
        end else begin
            check(step_cnt == ts + 1, "R5 write enable lead time", step_cnt, ts + 1);
        end
        @(negedge clk);
        start = 1'b0;
        check(!done && !busy, "R11 done single cycle, idle after", {done, busy}, 0);
        check(fail_blk == (exp_fail ? BIW'(exp_fb) : '0), "R11 fail_blk held",
              fail_blk, exp_fail ? exp_fb : 0);
    endtask

    task automatic set_need(input int v);
        for (int i = 0; i < NB*BW; i++) need[i] = v;
    endtask

    initial begin
        #(8 * 200000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h1F2E3D);
        ep_prev = 1'b0;
        set_need(0);
        for (int b = 0; b < NB; b++) pcnt[b] = 0;
        repeat (3) @(negedge clk);
        check({busy, done, fail, fl_wen, fl_esetup, fl_epulse, fl_verify, mem_we, mem_re} == 0,
              "R1 outputs in reset", busy, 0);
        check(fl_blk_sel == 0, "R1 block select in reset", fl_blk_sel, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: empty mask
        run_op(4'b0000, 2, 1, 1, 1, 0);
        // R7: all blocks erase on first pulse
        set_need(0);
        run_op(4'b0101, 2, 2, 3, 1, 0);
        // R8: slow last word of block 2, limit equal to need
        set_need(1);
        need[2*BW + BW - 1] = 3;
        run_op(4'b1111, 3, 1, 2, 0, 0);
        // R9: limit one below need, block 3 left untouched
        run_op(4'b1111, 2, 0, 1, 2, 0);
        // R9: limit zero means a single pulse
        set_need(1);
        need[1*BW + 3] = 2;
        run_op(4'b1110, 0, 1, 0, 0, 0);
        // R11: failure state cleared by next start
        run_op(4'b0000, 1, 0, 0, 0, 0);
        // R10: start while busy with a different mask is ignored
        set_need(1);
        run_op(4'b0010, 2, 1, 1, 1, 25);

        for (int k = 0; k < 24; k++) begin
            logic [NB-1:0] m;
            for (int i = 0; i < NB*BW; i++) need[i] = int'($urandom % 3);
            if ($urandom % 4 == 0) need[$urandom % (NB*BW)] = 5;
            m = NB'($urandom);
            run_op(m, int'($urandom % 5), int'($urandom % 4), int'($urandom % 4),
                   int'($urandom % 4), (k % 5 == 0) ? 17 : 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule